// File: doc/BRIEF.md
# Fan Duty Ramp-Rate Limiter

This block sits between a fan-speed calculation and a PWM generator and slows down how fast the applied duty may change, so that fan speed drifts audibly less when the temperature-derived duty jumps. Each channel holds a ramped duty register. While a channel's limiter is switched on, the register moves by exactly one count (1/255 of full scale) toward the requested target each time that channel's step timer expires; while it is switched off, the register copies the target on the next clock.

The step timer of each channel counts strobes of a shared base tick (nominally 90 kHz) up to an interval picked by a 3-bit rate code, from 5 ms at the fastest to 206 ms at the slowest. The number of base ticks per millisecond is a parameter, so the same logic serves any base rate. Target, ramped duty and PWM period are not phase-related; everything runs in one clock domain, advanced only by the base tick.

All pins are level-valued control and status: the target is a continuously held value that the block samples every clock, and the ramped duty is a held register that the PWM generator samples whenever it starts a period. There is no transfer to accept or refuse, so the block has no valid/ready handshake and applies no back-pressure; a new target simply replaces the old one.

Top module: `ramp_rate_limiter`

## Requirements
- R1: During and right after reset every channel's ramped duty reads 00h.
- R2: While a channel's enable is 0, its ramped duty equals the target it saw on the previous clock edge.
- R3: While enabled, a channel's ramped duty changes by at most one count per step and is unchanged on every clock without a step.
- R4: Rate code values 0 to 7 select step intervals of 206, 104, 69, 41, 26, 18, 10 and 5 ms respectively, each ms counting TICKS_PER_MS base ticks; a step falls on every interval-th base tick.
- R5: When the target is above the ramped duty, each step adds one, and the duty never passes the target (no wrap past FFh).
- R6: When the target is below the ramped duty, each step subtracts one, and the duty never passes the target (no wrap below 00h).
- R7: When the ramped duty equals the target, steps leave it unchanged.
- R8: A change of a channel's rate code restarts its interval count: no step occurs on the clock that sees the change, and the next step comes a full new interval of base ticks after that clock.
- R9: While a channel is disabled its interval count is held at zero, so after enabling the first step arrives a full interval of base ticks later.
- R10: Channels are independent: each uses only its own enable, rate code and target.
- R11: The interval count advances only on clocks where base_tick is 1; without base ticks no step occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_tick | input | 1 | One-clock strobe at the base rate (nominally 90 kHz) |
| ramp_en | input | NUM_CH | Per-channel limiter enable |
| rate_code | input | NUM_CH*3 | Per-channel rate code, channel c in bits [3c+2:3c] |
| target_duty | input | NUM_CH*DUTY_W | Per-channel requested duty, channel c in bits [DUTY_W*c +: DUTY_W] |
| ramped_duty | output | NUM_CH*DUTY_W | Per-channel limited duty toward the PWM generator |

## Verification
The assertions take base_tick to be a strobe that may be high on any number of consecutive clocks, a rate code that may change on any clock, and a target of any value at any time; they make no assumption about a minimum spacing between input changes. The bench changes inputs only between clock edges, sweeps all eight rate codes across the three channels at once with different directions and end points (including the FFh and 00h limits), repeats a sweep with a sparse base tick, and reverses a ramp and switches a rate code mid-interval at points it chooses so that the expected step times follow from plain arithmetic on the base-tick count.

// File: rtl/fan_ramp_pkg.sv
package fan_ramp_pkg;

  localparam int RATE_CODE_W = 3;
  localparam int SLOWEST_MS  = 206;

  // Step interval in milliseconds for each rate code.
  function automatic int rate_interval_ms(input logic [RATE_CODE_W-1:0] code);
    case (code)
      3'd0:    return 206;
      3'd1:    return 104;
      3'd2:    return 69;
      3'd3:    return 41;
      3'd4:    return 26;
      3'd5:    return 18;
      3'd6:    return 10;
      default: return 5;
    endcase
  endfunction

endpackage

// File: rtl/ramp_step_timer.sv
module ramp_step_timer
  import fan_ramp_pkg::*;
#(
  parameter int TICKS_PER_MS = 90
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   base_tick_i,
  input  logic                   en_i,
  input  logic [RATE_CODE_W-1:0] rate_i,
  output logic                   step_o
);

  localparam int MAX_TICKS = SLOWEST_MS * TICKS_PER_MS;
  localparam int CNT_W     = $clog2(MAX_TICKS);

  logic [CNT_W-1:0]       cnt_q;
  logic [CNT_W-1:0]       term_m1;
  logic [RATE_CODE_W-1:0] prev_rate_q;
  logic                   rate_chg;
  logic                   at_term;

  assign term_m1  = CNT_W'(rate_interval_ms(rate_i) * TICKS_PER_MS - 1);
  assign rate_chg = (rate_i != prev_rate_q);
  assign at_term  = (cnt_q == term_m1);
  assign step_o   = en_i && base_tick_i && !rate_chg && at_term;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_rate_q <= '0;
    end else begin
      prev_rate_q <= rate_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!en_i || rate_chg) begin
      cnt_q <= '0;
    end else if (base_tick_i) begin
      if (at_term) cnt_q <= '0;
      else         cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_rate_q == rate_i) |-> (cnt_q <= term_m1)); // R4

  AST_WRAP_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |=> (cnt_q == '0)); // R4

  AST_RATE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_i != prev_rate_q) |=> (cnt_q == '0)); // R8

  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (cnt_q == '0)); // R9

  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !base_tick_i && (rate_i == prev_rate_q)) |=> $stable(cnt_q)); // R11

endmodule

// File: rtl/ramp_duty_tracker.sv
module ramp_duty_tracker #(
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              step_i,
  input  logic [DUTY_W-1:0] target_i,
  output logic [DUTY_W-1:0] duty_o
);

  logic [DUTY_W-1:0] duty_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      duty_q <= '0;
    end else if (!en_i) begin
      duty_q <= target_i;
    end else if (step_i) begin
      if (target_i > duty_q)      duty_q <= duty_q + DUTY_W'(1);
      else if (target_i < duty_q) duty_q <= duty_q - DUTY_W'(1);
    end
  end

  assign duty_o = duty_q;

  AST_BYPASS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (duty_o == $past(target_i))); // R2

  AST_QUIET_BETWEEN_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !step_i) |=> $stable(duty_o)); // R3

  AST_UP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && step_i && (duty_o < target_i)) |=> (duty_o == $past(duty_o) + DUTY_W'(1))); // R5

  AST_DOWN_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && step_i && (duty_o > target_i)) |=> (duty_o == $past(duty_o) - DUTY_W'(1))); // R6

  AST_SETTLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && (duty_o == target_i)) |=> $stable(duty_o)); // R7

endmodule

// File: rtl/ramp_rate_limiter.sv
module ramp_rate_limiter
  import fan_ramp_pkg::*;
#(
  parameter int NUM_CH       = 3,
  parameter int DUTY_W       = 8,
  parameter int TICKS_PER_MS = 90
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          base_tick,
  input  logic [NUM_CH-1:0]             ramp_en,
  input  logic [NUM_CH*RATE_CODE_W-1:0] rate_code,
  input  logic [NUM_CH*DUTY_W-1:0]      target_duty,
  output logic [NUM_CH*DUTY_W-1:0]      ramped_duty
);

  logic [NUM_CH-1:0] step;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    ramp_step_timer #(
      .TICKS_PER_MS(TICKS_PER_MS)
    ) i_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .base_tick_i(base_tick),
      .en_i       (ramp_en[c]),
      .rate_i     (rate_code[c*RATE_CODE_W +: RATE_CODE_W]),
      .step_o     (step[c])
    );

    ramp_duty_tracker #(
      .DUTY_W(DUTY_W)
    ) i_tracker (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_i    (ramp_en[c]),
      .step_i  (step[c]),
      .target_i(target_duty[c*DUTY_W +: DUTY_W]),
      .duty_o  (ramped_duty[c*DUTY_W +: DUTY_W])
    );

    AST_STEP_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      step[c] |-> ramp_en[c]); // R10
  end

  AST_RESET_ZERO: assert property (@(posedge clk)
    !rst_n |=> (ramped_duty == '0)); // R1

endmodule

// File: tb/test_ramp_rate_limiter.sv
`timescale 1ns/1ps
module test_ramp_rate_limiter;

  localparam int NCH = 3;
  localparam int DW  = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              base_tick;
  logic [NCH-1:0]    ramp_en;
  logic [NCH*3-1:0]  rate_code;
  logic [NCH*DW-1:0] target_duty;
  logic [NCH*DW-1:0] ramped_duty;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  ramp_rate_limiter #(
    .NUM_CH(NCH), .DUTY_W(DW), .TICKS_PER_MS(1)
  ) i_ramp_rate_limiter (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .ramp_en(ramp_en),
    .rate_code(rate_code), .target_duty(target_duty), .ramped_duty(ramped_duty)
  );

  // Interval table of R4, with one base tick per ms.
  function automatic int interval_of(input int code);
    case (code)
      0: return 206;
      1: return 104;
      2: return 69;
      3: return 41;
      4: return 26;
      5: return 18;
      6: return 10;
      default: return 5;
    endcase
  endfunction

  function automatic int duty_of(input int c);
    return int'(ramped_duty[c*DW +: DW]);
  endfunction

  task automatic chk(input string tag, input int c, input int exp);
    int act;
    act = duty_of(c);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s ch%0d actual=%0d expected=%0d at %0t", tag, c, act, exp, $time);
    end
  endtask

  task automatic set_ch(input int c, input bit en, input int code, input int tgt);
    ramp_en[c]            = en;
    rate_code[c*3 +: 3]   = 3'(code);
    target_duty[c*DW +: DW] = DW'(tgt);
  endtask

  // Ramp all channels at once with distinct codes; per = base tick spacing.
  task automatic run_case(input int kbase, input int per);
    int code[NCH]; int t0[NCH]; int t1[NCH]; int n[NCH]; int diff[NCH]; int sgn[NCH];
    int len; int ticks; int exp; int steps;
    len = 0;
    for (int c = 0; c < NCH; c++) begin
      code[c] = (kbase + c) % 8;
      n[c]    = interval_of(code[c]);
      if (c == 0)            begin t0[c] = 20;  t1[c] = 26;  end
      else if (c == 1)       begin t0[c] = 200; t1[c] = 194; end
      else if (kbase % 2 == 0) begin t0[c] = 250; t1[c] = 255; end
      else                   begin t0[c] = 4;   t1[c] = 0;   end
      sgn[c]  = (t1[c] > t0[c]) ? 1 : -1;
      diff[c] = (t1[c] > t0[c]) ? t1[c] - t0[c] : t0[c] - t1[c];
      if (n[c] * per * (diff[c] + 2) > len) len = n[c] * per * (diff[c] + 2);
    end
    @(negedge clk);
    base_tick = 1'b1;
    for (int c = 0; c < NCH; c++) set_ch(c, 1'b0, code[c], t0[c]);
    repeat (2) @(negedge clk);
    for (int c = 0; c < NCH; c++) chk("R2 setup", c, t0[c]);
    for (int c = 0; c < NCH; c++) set_ch(c, 1'b1, code[c], t1[c]);
    ticks = 0;
    for (int e = 1; e <= len; e++) begin
      base_tick = ((e % per) == 0);
      @(negedge clk);
      if (base_tick) ticks++;
      for (int c = 0; c < NCH; c++) begin
        steps = ticks / n[c];
        if (steps > diff[c]) steps = diff[c];
        exp = t0[c] + sgn[c] * steps;
        if (per > 1)          chk("R11 R3 R4", c, exp);
        else if (sgn[c] > 0)  chk("R4 R9 R10 R5 R7", c, exp);
        else                  chk("R4 R9 R10 R6 R7", c, exp);
      end
    end
    base_tick = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; base_tick = 1'b0; ramp_en = '0; rate_code = '0;
    target_duty = {NCH{8'h55}};
    repeat (3) @(negedge clk);
    for (int c = 0; c < NCH; c++) chk("R1 in reset", c, 0);
    target_duty = '0;
    rst_n = 1'b1;
    @(negedge clk);
    for (int c = 0; c < NCH; c++) chk("R1 after reset", c, 0);

    // R2: bypass follows target one clock later, each channel a different pattern.
    base_tick = 1'b1;
    for (int i = 0; i < 24; i++) begin
      for (int c = 0; c < NCH; c++) set_ch(c, 1'b0, c, (i * 37 + c * 91 + 3) & 255);
      @(negedge clk);
      for (int c = 0; c < NCH; c++) chk("R2 bypass", c, (i * 37 + c * 91 + 3) & 255);
    end

    // Exhaustive code sweep, all channels concurrently.
    for (int k = 0; k < 8; k++) run_case(k, 1);
    // Sparse base tick.
    run_case(5, 3);

    // R8: code change mid-interval restarts the count.
    @(negedge clk);
    for (int c = 0; c < NCH; c++) set_ch(c, 1'b0, 0, 0);
    repeat (2) @(negedge clk);
    set_ch(0, 1'b1, 0, 50);
    for (int e = 1; e <= 100; e++) begin
      @(negedge clk);
      chk("R8 before change", 0, 0);
    end
    rate_code[2:0] = 3'd7;
    for (int e = 1; e <= 31; e++) begin
      @(negedge clk);
      chk("R8 after change", 0, (e - 1) / 5);
    end

    // R6: reversal right after a step.
    set_ch(0, 1'b0, 7, 100);
    repeat (2) @(negedge clk);
    set_ch(0, 1'b1, 7, 110);
    for (int e = 1; e <= 15; e++) begin
      @(negedge clk);
      chk("R5 before reversal", 0, 100 + e / 5);
    end
    target_duty[7:0] = 8'd98;
    for (int e = 1; e <= 40; e++) begin
      @(negedge clk);
      chk("R6 reversal", 0, 103 - ((e / 5 > 5) ? 5 : e / 5));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule